// File: doc/BRIEF.md
# Five-Level Confidence Branch Direction Predictor

This block predicts the direction of conditional branches. It keeps a table of confidence entries indexed by the low bits of the branch address. Each entry holds one of five levels instead of the common two-bit counter. The two low levels predict not taken and the two high levels predict taken. The centre level has no fixed direction: there, a free-running pseudo-random bit chooses the direction. Resolved outcomes move the addressed entry one level towards the observed direction.

The table is shared by many addresses, so a small tag store sits beside it to report sharing. The tag store is indexed by the low address bits and holds the upper address bits of its last owner. Every request carries an operation code:

- predict
- install a history tag
- train the predictor
- look up a history tag

A request whose index holds a valid tag from another address raises an alias event. That event carries the requesting address, the stored address and the operation code.

Predictions come back as an event that carries the caller's instruction id and the direction. Two counters give the number of accepted predictions and the number of mispredictions. A build option restricts predictions to every other cycle. This models a front end that can only consult the predictor on alternate cycles.

Top module: `thresh_bpred`

## Requirements
- R1: After reset every confidence entry is at level 3, so a first prediction returns taken; the tag store is empty, no event is raised and both counters read zero.
- R2: A prediction from level 0 or 1 returns not taken (direction 0), and from level 3 or 4 returns taken (direction 1).
- R3: A prediction from level 2 returns bit 0 of a 16-bit LFSR. The LFSR is seeded with 0xACE1 at reset. After each level-2 prediction, and only then, it shifts left, and bit 0 takes bit15 ^ bit13 ^ bit12 ^ bit10.
- R4: A train request moves its entry up one level for a taken outcome and down one level for a not-taken outcome, saturating at 0 and 4.
- R5: One cycle after a predict request is accepted, the prediction event is valid with the request's id and the direction; in the cycle after any other request, or no request, it is not valid.
- R6: The request code is 0 predict, 1 install tag, 2 train, 3 look up tag. Codes 1 and 3 leave every confidence entry unchanged.
- R7: Tag store index is address bits [log2(HIST_ENTRIES)-1:0] and tag is the remaining upper bits. Any request whose index holds a valid, different tag raises the alias event one cycle later. The event carries the request address, the stored address (stored tag above index) and the request code.
- R8: The prediction counter increases by one for each accepted predict request and for nothing else.
- R9: A train request increases the misprediction counter when its outcome differs from the most recent prediction of the same entry not yet matched by a train. That prediction is then consumed; a train with no such prediction counts nothing.
- R10: With the alternate-cycle option set, predict requests are ready only on even cycles (the first cycle after reset is even), and stalled ones count nothing. Codes 1 to 3 are always ready; without the option every request is ready.
- R11: Codes 1 and 2 write the request tag into the tag store, after which the same address raises no alias; codes 0 and 3 leave the tag store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Request code (0 predict, 1 install, 2 train, 3 look up) |
| req_addr | input | ADDR_W | Branch address |
| req_id | input | ID_W | Instruction id returned with a prediction |
| req_taken | input | 1 | Resolved outcome for a train request |
| req_ready | output | 1 | Request accepted this cycle when valid |
| evt_pred_valid | output | 1 | Prediction event valid |
| evt_pred_id | output | ID_W | Instruction id of the prediction |
| evt_pred_dir | output | 1 | Predicted direction, 1 taken |
| evt_alias_valid | output | 1 | Alias event valid |
| evt_alias_op | output | 2 | Request code that met the alias |
| evt_alias_addr | output | ADDR_W | Requesting address |
| evt_alias_stored | output | ADDR_W | Address of the stored owner |
| pred_count | output | CNT_W | Accepted predictions |
| mispred_count | output | CNT_W | Mispredictions |

## Verification
The centre level is the hardest case to control. Its direction depends on the LFSR history, which advances only on centre-level predictions. An entry must first be walked down from its reset level with train requests, and then predicted several times in a row. The bench keeps its own LFSR and per-entry level model and steps them on exactly those predictions. This exposes a wrong seed, wrong taps or an advance on the wrong cycle. The saturation edges are reached by over-training one entry in both directions. Single trains then move it back, and its reported direction shows that no level was lost past either end.

// File: rtl/thresh_bpred_pkg.sv
package thresh_bpred_pkg;

   typedef enum logic [1:0] {
      OP_PREDICT      = 2'd0,
      OP_HIST_INSTALL = 2'd1,
      OP_TRAIN        = 2'd2,
      OP_HIST_LOOKUP  = 2'd3
   } bp_op_e;

   typedef logic [2:0] conf_t;

   localparam conf_t CONF_MIN  = 3'd0;
   localparam conf_t CONF_MID  = 3'd2;
   localparam conf_t CONF_MAX  = 3'd4;
   localparam conf_t CONF_INIT = 3'd3;

   function automatic conf_t conf_step(input conf_t lvl, input logic taken);
      conf_t nxt;
      if (taken) nxt = (lvl >= CONF_MAX) ? CONF_MAX : conf_t'(lvl + 3'd1);
      else       nxt = (lvl == CONF_MIN) ? CONF_MIN : conf_t'(lvl - 3'd1);
      return nxt;
   endfunction

   function automatic logic conf_dir(input conf_t lvl, input logic rnd);
      logic d;
      if (lvl > CONF_MID)      d = 1'b1;
      else if (lvl < CONF_MID) d = 1'b0;
      else                     d = rnd;
      return d;
   endfunction

endpackage

// File: rtl/tbp_lfsr.sv
module tbp_lfsr #(
   parameter int           WIDTH = 16,
   parameter logic [WIDTH-1:0] TAPS  = 16'hB400,
   parameter logic [WIDTH-1:0] SEED  = 16'hACE1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv_i,
   output logic bit_o
);

   logic [WIDTH-1:0] lfsr_q;

   initial assert (SEED != '0) else $error("tbp_lfsr: seed must be non-zero");
   initial assert (WIDTH >= 4) else $error("tbp_lfsr: width too small");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lfsr_q <= SEED;
      else if (adv_i) lfsr_q <= {lfsr_q[WIDTH-2:0], ^(lfsr_q & TAPS)};
   end

   assign bit_o = lfsr_q[0];

   p_lfsr_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);

   p_lfsr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(lfsr_q));

endmodule

// File: rtl/tbp_conf_table.sv
module tbp_conf_table
   import thresh_bpred_pkg::*;
#(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx_i,
   output conf_t            rd_lvl_o,
   input  logic             mark_en_i,
   input  logic             mark_dir_i,
   input  logic             trn_en_i,
   input  logic [IDX_W-1:0] trn_idx_i,
   input  logic             trn_taken_i,
   output logic             trn_pend_o,
   output logic             trn_pdir_o
);

   conf_t lvl_q  [ENTRIES];
   logic  pend_q [ENTRIES];
   logic  pdir_q [ENTRIES];

   initial assert (ENTRIES >= 2 && (1 << IDX_W) == ENTRIES)
      else $error("tbp_conf_table: ENTRIES must be a power of two");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            lvl_q[i]  <= CONF_INIT;
            pend_q[i] <= 1'b0;
            pdir_q[i] <= 1'b0;
         end
      end else begin
         if (trn_en_i) begin
            lvl_q[trn_idx_i]  <= conf_step(lvl_q[trn_idx_i], trn_taken_i);
            pend_q[trn_idx_i] <= 1'b0;
         end
         if (mark_en_i) begin
            pend_q[rd_idx_i] <= 1'b1;
            pdir_q[rd_idx_i] <= mark_dir_i;
         end
      end
   end

   assign rd_lvl_o   = lvl_q[rd_idx_i];
   assign trn_pend_o = pend_q[trn_idx_i];
   assign trn_pdir_o = pdir_q[trn_idx_i];

   p_lvl_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lvl_o <= CONF_MAX);

   p_one_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(mark_en_i && trn_en_i));

endmodule

// File: rtl/tbp_tag_table.sv
module tbp_tag_table #(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 9,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [TAG_W-1:0] tag_i,
   input  logic             wr_en_i,
   output logic             clash_o,
   output logic [TAG_W-1:0] owner_o
);

   logic             vld_q [ENTRIES];
   logic [TAG_W-1:0] tag_q [ENTRIES];

   initial assert (ENTRIES >= 2 && (1 << IDX_W) == ENTRIES)
      else $error("tbp_tag_table: ENTRIES must be a power of two");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            vld_q[i] <= 1'b0;
            tag_q[i] <= '0;
         end
      end else if (wr_en_i) begin
         vld_q[idx_i] <= 1'b1;
         tag_q[idx_i] <= tag_i;
      end
   end

   assign owner_o = tag_q[idx_i];
   assign clash_o = vld_q[idx_i] && (tag_q[idx_i] != tag_i);

   p_owner_after_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (tag_q[$past(idx_i)] == $past(tag_i)));

endmodule

// File: rtl/thresh_bpred.sv
module thresh_bpred
   import thresh_bpred_pkg::*;
#(
   parameter int ADDR_W          = 12,
   parameter int ID_W            = 8,
   parameter int CNT_W           = 16,
   parameter int PHT_ENTRIES     = 16,
   parameter int HIST_ENTRIES    = 8,
   parameter bit EVEN_CYCLE_ONLY = 1'b0,
   parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ID_W-1:0]   req_id,
   input  logic              req_taken,
   output logic              req_ready,
   output logic              evt_pred_valid,
   output logic [ID_W-1:0]   evt_pred_id,
   output logic              evt_pred_dir,
   output logic              evt_alias_valid,
   output logic [1:0]        evt_alias_op,
   output logic [ADDR_W-1:0] evt_alias_addr,
   output logic [ADDR_W-1:0] evt_alias_stored,
   output logic [CNT_W-1:0]  pred_count,
   output logic [CNT_W-1:0]  mispred_count
);

   localparam int PIDX_W = $clog2(PHT_ENTRIES);
   localparam int HIDX_W = $clog2(HIST_ENTRIES);
   localparam int TAG_W  = ADDR_W - HIDX_W;

   initial assert (ADDR_W > HIDX_W && ADDR_W >= PIDX_W)
      else $error("thresh_bpred: address narrower than table index");
   initial assert (CNT_W >= 1 && ID_W >= 1)
      else $error("thresh_bpred: counter and id widths must be positive");

   bp_op_e op;
   assign op = bp_op_e'(req_op);

   // alternate-cycle gating of predict requests
   logic odd_cycle;
   generate
      if (EVEN_CYCLE_ONLY) begin : g_alt
         logic phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) phase_q <= 1'b0;
            else        phase_q <= ~phase_q;
         end
         assign odd_cycle = phase_q;

         p_odd_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (phase_q && req_op == 2'd0) |-> !req_ready);
      end else begin : g_every
         assign odd_cycle = 1'b0;
      end
   endgenerate

   assign req_ready = (op != OP_PREDICT) || !odd_cycle;

   logic acc, do_pred, do_train, do_inst;
   assign acc      = req_valid && req_ready;
   assign do_pred  = acc && (op == OP_PREDICT);
   assign do_train = acc && (op == OP_TRAIN);
   assign do_inst  = acc && ((op == OP_HIST_INSTALL) || (op == OP_TRAIN));

   // confidence table and random source
   logic [PIDX_W-1:0] pidx;
   conf_t             cur_lvl;
   logic              rnd_bit, dir, pend, pdir;

   assign pidx = req_addr[PIDX_W-1:0];

   tbp_lfsr #(.WIDTH(16), .TAPS(16'hB400), .SEED(LFSR_SEED)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (do_pred && (cur_lvl == CONF_MID)),
      .bit_o (rnd_bit)
   );

   assign dir = conf_dir(cur_lvl, rnd_bit);

   tbp_conf_table #(.ENTRIES(PHT_ENTRIES)) u_conf (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_idx_i    (pidx),
      .rd_lvl_o    (cur_lvl),
      .mark_en_i   (do_pred),
      .mark_dir_i  (dir),
      .trn_en_i    (do_train),
      .trn_idx_i   (pidx),
      .trn_taken_i (req_taken),
      .trn_pend_o  (pend),
      .trn_pdir_o  (pdir)
   );

   // alias detection
   logic [HIDX_W-1:0] hidx;
   logic [TAG_W-1:0]  htag, owner;
   logic              clash;

   assign hidx = req_addr[HIDX_W-1:0];
   assign htag = req_addr[ADDR_W-1:HIDX_W];

   tbp_tag_table #(.ENTRIES(HIST_ENTRIES), .TAG_W(TAG_W)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_i   (hidx),
      .tag_i   (htag),
      .wr_en_i (do_inst),
      .clash_o (clash),
      .owner_o (owner)
   );

   logic missed;
   assign missed = do_train && pend && (pdir != req_taken);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_pred_valid   <= 1'b0;
         evt_pred_id      <= '0;
         evt_pred_dir     <= 1'b0;
         evt_alias_valid  <= 1'b0;
         evt_alias_op     <= 2'd0;
         evt_alias_addr   <= '0;
         evt_alias_stored <= '0;
         pred_count       <= '0;
         mispred_count    <= '0;
      end else begin
         evt_pred_valid  <= do_pred;
         evt_alias_valid <= acc && clash;
         if (do_pred) begin
            evt_pred_id  <= req_id;
            evt_pred_dir <= dir;
            pred_count   <= pred_count + 1'b1;
         end
         if (acc && clash) begin
            evt_alias_op     <= req_op;
            evt_alias_addr   <= req_addr;
            evt_alias_stored <= {owner, hidx};
         end
         if (missed) mispred_count <= mispred_count + 1'b1;
      end
   end

   p_pred_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_op == 2'd0) |=> evt_pred_valid);

   p_no_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready && req_op == 2'd0) |=> !evt_pred_valid);

   p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pred_valid |-> (pred_count == $past(pred_count) + 1'b1));

   p_alias_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!evt_alias_valid || evt_alias_op == $past(req_op)));

   p_mis_only_train_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready && req_op == 2'd2) |=> $stable(mispred_count));

endmodule

// File: tb/thresh_bpred_tb.sv
module thresh_bpred_tb;

   localparam int AW = 12;
   localparam int IW = 8;
   localparam int CW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [IW-1:0] req_id = '0;
   logic          req_taken = 1'b0;
   logic          req_ready;
   logic          evt_pred_valid, evt_pred_dir, evt_alias_valid;
   logic [IW-1:0] evt_pred_id;
   logic [1:0]    evt_alias_op;
   logic [AW-1:0] evt_alias_addr, evt_alias_stored;
   logic [CW-1:0] pred_count, mispred_count;

   thresh_bpred #(.ADDR_W(AW), .ID_W(IW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_id(req_id), .req_taken(req_taken),
      .req_ready(req_ready), .evt_pred_valid(evt_pred_valid),
      .evt_pred_id(evt_pred_id), .evt_pred_dir(evt_pred_dir),
      .evt_alias_valid(evt_alias_valid), .evt_alias_op(evt_alias_op),
      .evt_alias_addr(evt_alias_addr), .evt_alias_stored(evt_alias_stored),
      .pred_count(pred_count), .mispred_count(mispred_count));

   logic          e_valid = 1'b0;
   logic [1:0]    e_op = 2'd0;
   logic          e_ready, e_pv, e_pd, e_av;
   logic [IW-1:0] e_pid;
   logic [1:0]    e_aop;
   logic [AW-1:0] e_aaddr, e_astored;
   logic [CW-1:0] e_pc, e_mc;

   thresh_bpred #(.ADDR_W(AW), .ID_W(IW), .CNT_W(CW), .EVEN_CYCLE_ONLY(1'b1)) u_dut_even (
      .clk(clk), .rst_n(rst_n), .req_valid(e_valid), .req_op(e_op),
      .req_addr(12'h123), .req_id(8'h5A), .req_taken(1'b1),
      .req_ready(e_ready), .evt_pred_valid(e_pv),
      .evt_pred_id(e_pid), .evt_pred_dir(e_pd),
      .evt_alias_valid(e_av), .evt_alias_op(e_aop),
      .evt_alias_addr(e_aaddr), .evt_alias_stored(e_astored),
      .pred_count(e_pc), .mispred_count(e_mc));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model built from the requirements
   logic [2:0]  m_lvl  [16];
   logic        m_pend [16];
   logic        m_pdir [16];
   logic        m_hv   [8];
   logic [8:0]  m_htag [8];
   logic [15:0] m_lfsr;
   int          m_pc, m_mc;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 16; i++) begin
         m_lvl[i] = 3'd3; m_pend[i] = 1'b0; m_pdir[i] = 1'b0;
      end
      for (int i = 0; i < 8; i++) begin
         m_hv[i] = 1'b0; m_htag[i] = '0;
      end
      m_lfsr = 16'hACE1; m_pc = 0; m_mc = 0;
   endtask

   task automatic do_req(input logic [1:0] op, input logic [AW-1:0] addr,
                         input logic [IW-1:0] id, input logic taken);
      logic [3:0] pi;
      logic [2:0] hi;
      logic [8:0] ht;
      logic       ex_alias, ex_dir;
      logic [AW-1:0] ex_stored;
      string      dtag;
      pi = addr[3:0]; hi = addr[2:0]; ht = addr[11:3];
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = addr; req_id = id; req_taken = taken;
      #1;
      chk("R10 ready", {31'd0, req_ready}, 32'd1);
      ex_alias  = m_hv[hi] && (m_htag[hi] != ht);
      ex_stored = {m_htag[hi], hi};
      ex_dir    = 1'b0;
      dtag      = "R2";
      if (op == 2'd0) begin
         if (m_lvl[pi] == 3'd2) begin
            dtag   = "R3";
            ex_dir = m_lfsr[0];
            m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
         end else begin
            ex_dir = (m_lvl[pi] > 3'd2);
            if (m_lvl[pi] == 3'd0 || m_lvl[pi] == 3'd4) dtag = "R4 R2";
         end
         m_pend[pi] = 1'b1; m_pdir[pi] = ex_dir; m_pc++;
      end
      if (op == 2'd2) begin
         if (m_pend[pi] && m_pdir[pi] != taken) m_mc++;
         m_pend[pi] = 1'b0;
         if (taken) m_lvl[pi] = (m_lvl[pi] == 3'd4) ? 3'd4 : m_lvl[pi] + 3'd1;
         else       m_lvl[pi] = (m_lvl[pi] == 3'd0) ? 3'd0 : m_lvl[pi] - 3'd1;
      end
      if (op == 2'd1 || op == 2'd2) begin
         m_hv[hi] = 1'b1; m_htag[hi] = ht;
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk("R5 pred valid", {31'd0, evt_pred_valid}, {31'd0, op == 2'd0});
      if (op == 2'd0) begin
         chk(dtag, {31'd0, evt_pred_dir}, {31'd0, ex_dir});
         chk("R5 id", {24'd0, evt_pred_id}, {24'd0, id});
      end
      chk("R7 alias valid", {31'd0, evt_alias_valid}, {31'd0, ex_alias});
      if (ex_alias) begin
         chk("R7 alias addr", {20'd0, evt_alias_addr}, {20'd0, addr});
         chk("R7 alias stored", {20'd0, evt_alias_stored}, {20'd0, ex_stored});
         chk("R7 alias op", {30'd0, evt_alias_op}, {30'd0, op});
      end
      chk("R8 pred count", {16'd0, pred_count}, m_pc);
      chk("R9 mispred count", {16'd0, mispred_count}, m_mc);
   endtask

   task automatic t_reset_r1();
      chk("R1 pred evt", {31'd0, evt_pred_valid}, 32'd0);
      chk("R1 alias evt", {31'd0, evt_alias_valid}, 32'd0);
      chk("R1 pred count", {16'd0, pred_count}, 32'd0);
      chk("R1 mispred count", {16'd0, mispred_count}, 32'd0);
      do_req(2'd0, 12'h0A7, 8'h11, 1'b0);
      chk("R1 first dir", {31'd0, evt_pred_dir}, 32'd1);
   endtask

   task automatic t_saturate_r4();
      for (int i = 0; i < 6; i++) do_req(2'd2, 12'h025, 8'h00, 1'b0);
      do_req(2'd0, 12'h025, 8'h21, 1'b0);
      do_req(2'd2, 12'h025, 8'h00, 1'b1);
      do_req(2'd0, 12'h025, 8'h22, 1'b0);
      chk("R4 low saturation", {31'd0, evt_pred_dir}, 32'd0);
      for (int i = 0; i < 7; i++) do_req(2'd2, 12'h025, 8'h00, 1'b1);
      do_req(2'd0, 12'h025, 8'h23, 1'b0);
      do_req(2'd2, 12'h025, 8'h00, 1'b0);
      do_req(2'd0, 12'h025, 8'h24, 1'b0);
      chk("R4 high saturation", {31'd0, evt_pred_dir}, 32'd1);
   endtask

   task automatic t_middle_r3();
      do_req(2'd2, 12'h03C, 8'h00, 1'b0);
      for (int i = 0; i < 10; i++) do_req(2'd0, 12'h03C, 8'(8'h30 + i), 1'b0);
      do_req(2'd0, 12'h0AB, 8'h3F, 1'b0);
   endtask

   task automatic t_alias_r7();
      do_req(2'd1, 12'h008, 8'h00, 1'b0);
      do_req(2'd3, 12'h010, 8'h00, 1'b0);
      do_req(2'd3, 12'h010, 8'h00, 1'b0);
      chk("R11 lookup keeps owner", {31'd0, evt_alias_valid}, 32'd1);
      do_req(2'd0, 12'h010, 8'h41, 1'b0);
      do_req(2'd2, 12'h010, 8'h00, 1'b1);
      do_req(2'd3, 12'h010, 8'h00, 1'b0);
      chk("R11 train installs", {31'd0, evt_alias_valid}, 32'd0);
      do_req(2'd1, 12'h008, 8'h00, 1'b0);
      do_req(2'd0, 12'hFF8, 8'h42, 1'b0);
   endtask

   task automatic t_ops_r6();
      do_req(2'd0, 12'h005, 8'h51, 1'b0);
      for (int i = 0; i < 3; i++) begin
         do_req(2'd1, 12'h005, 8'h00, 1'b0);
         do_req(2'd3, 12'h105, 8'h00, 1'b1);
      end
      do_req(2'd0, 12'h005, 8'h52, 1'b0);
      chk("R6 level kept high", {31'd0, evt_pred_dir}, 32'd1);
      do_req(2'd2, 12'h005, 8'h00, 1'b0);
      do_req(2'd2, 12'h005, 8'h00, 1'b0);
      for (int i = 0; i < 3; i++) do_req(2'd3, 12'h005, 8'h00, 1'b1);
      do_req(2'd0, 12'h005, 8'h53, 1'b0);
      chk("R6 level kept low", {31'd0, evt_pred_dir}, 32'd0);
   endtask

   task automatic t_mispred_r9();
      int base;
      base = m_mc;
      do_req(2'd2, 12'h00A, 8'h00, 1'b0);
      chk("R9 no prior prediction", {16'd0, mispred_count}, base);
      do_req(2'd0, 12'h00B, 8'h61, 1'b0);
      do_req(2'd2, 12'h00B, 8'h00, 1'b0);
      chk("R9 wrong direction", {16'd0, mispred_count}, base + 1);
      do_req(2'd2, 12'h00B, 8'h00, 1'b1);
      chk("R9 consumed", {16'd0, mispred_count}, base + 1);
      do_req(2'd0, 12'h00B, 8'h62, 1'b0);
      do_req(2'd2, 12'h00B, 8'h00, evt_pred_dir);
      chk("R9 correct direction", {16'd0, mispred_count}, base + 1);
   endtask

   task automatic t_even_r10();
      logic r [4];
      int   acc;
      acc = 0;
      @(negedge clk);
      e_valid = 1'b1; e_op = 2'd0;
      for (int i = 0; i < 4; i++) begin
         #1;
         r[i] = e_ready;
         if (e_ready) acc++;
         @(negedge clk);
      end
      e_valid = 1'b0;
      chk("R10 alternation 0-1", {31'd0, r[0] ^ r[1]}, 32'd1);
      chk("R10 alternation 1-2", {31'd0, r[1] ^ r[2]}, 32'd1);
      chk("R10 accepted half", acc, 32'd2);
      @(negedge clk);
      chk("R10 stalled not counted", {16'd0, e_pc}, 32'd2);
      e_valid = 1'b1; e_op = 2'd1;
      #1;
      chk("R10 install ready a", {31'd0, e_ready}, 32'd1);
      @(negedge clk); #1;
      chk("R10 install ready b", {31'd0, e_ready}, 32'd1);
      e_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_r1();
      t_saturate_r4();
      t_middle_r3();
      t_alias_r7();
      t_ops_r6();
      t_mispred_r9();
      t_even_r10();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule